// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block runs integer multiply and divide operations beside the main datapath of a scalar core. It keeps their results in two dedicated result registers, HI and LO. A product of two W-bit operands is 2W bits wide: its upper half lands in HI and its lower half in LO. A division puts the quotient in LO and the remainder in HI. Software can also write either register directly and read both at any time.

An operation is launched by raising `start` for one cycle with an operation code and operands. Multiplies run through a short fixed pipeline. Divides use a restoring algorithm that produces one quotient bit per cycle. While `busy` is high, the requester must not read HI/LO and must not launch new work. A strobe raised during that time is discarded. HI and LO never expose a partially formed result.

Top module: `hilo_muldiv`

## Requirements
- R1: While `rst` is high and on the cycle after it, `busy` is 0 and both HI and LO read 0.
- R2: Operation code 0 (signed multiply) leaves the 2W-bit two's-complement product of `opa` and `opb` with its upper half in HI and its lower half in LO.
- R3: Operation code 1 (unsigned multiply) leaves the 2W-bit unsigned product with the same split (upper half in HI, lower half in LO).
- R4: Operation code 2 (signed divide) leaves the quotient in LO, rounded toward zero, and the remainder in HI, carrying the sign of the dividend. The most negative value divided by -1 gives LO equal to the most negative value and HI equal to 0.
- R5: Operation code 3 (unsigned divide) leaves the unsigned quotient in LO and the unsigned remainder in HI.
- R6: A divide by zero, signed or unsigned, finishes in the usual number of cycles and leaves LO all ones and HI equal to the dividend.
- R7: Operation code 4 copies `opa` into HI and operation code 5 copies `opa` into LO on the launching edge. The other register is unchanged and `busy` stays low.
- R8: After an accepted multiply, `busy` is high for exactly MUL_LAT cycles. After an accepted divide, it is high for exactly W+1 cycles. HI and LO keep their previous values until `busy` falls.
- R9: A `start` raised while `busy` is high is ignored: it writes neither register and does not alter the running operation's result.
- R10: Operation codes 6 and 7 change neither HI nor LO and leave `busy` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle launch strobe |
| op | input | 3 | Operation code (0..5 defined, 6..7 reserved) |
| opa | input | W | First operand: multiplicand, dividend or move-to data |
| opb | input | W | Second operand: multiplier or divisor |
| hi_o | output | W | Registered HI value |
| lo_o | output | W | Registered LO value |
| busy | output | 1 | High while a multiply or divide is in flight |

## Verification
Several situations are hard to reach from the ports. One is a strobe arriving during a long divide. Others are divide-by-zero and the single overflowing signed quotient, since each needs one exact operand pair. A small six-bit configuration is swept over every operand pair for all four arithmetic operations. That sweep reaches the zero-divisor and most-negative-by-minus-one cases without special setup. A directed sequence raises a move-to strobe on the cycle right after a divide is accepted. It then confirms that the divide's remainder, and not the move-to data, reaches HI.

// File: rtl/hilo_pkg.sv
package hilo_pkg;
  typedef enum logic [2:0] {
    OP_MULS = 3'd0,
    OP_MULU = 3'd1,
    OP_DIVS = 3'd2,
    OP_DIVU = 3'd3,
    OP_MTHI = 3'd4,
    OP_MTLO = 3'd5
  } hilo_op_e;
endpackage

// File: rtl/hilo_mul.sv
module hilo_mul #(
  parameter int W   = 32,
  parameter int LAT = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           go,
  input  logic           sgn,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic           done,
  output logic [2*W-1:0] prod
);
  localparam int PW = 2 * W;

  logic signed [W:0]    a_ext, b_ext;
  logic signed [PW+1:0] full;
  logic [LAT-1:0]       vld;
  logic [PW-1:0]        stg [LAT];

  assign a_ext = {sgn & a[W-1], a};
  assign b_ext = {sgn & b[W-1], b};
  assign full  = a_ext * b_ext;

  always_ff @(posedge clk) begin
    if (rst) vld[0] <= 1'b0;
    else     vld[0] <= go;
    if (go) stg[0] <= full[PW-1:0];
  end

  for (genvar i = 1; i < LAT; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) vld[i] <= 1'b0;
      else     vld[i] <= vld[i-1];
      stg[i] <= stg[i-1];
    end
  end

  assign done = vld[LAT-1];
  assign prod = stg[LAT-1];
endmodule

// File: rtl/hilo_div.sv
module hilo_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic         sgn,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         done,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  q_r, r_r, d_r;
  logic [CW-1:0] cnt;
  logic          active, done_r, neg_q, neg_r, dz;
  logic [W:0]    sh;
  logic          fit;

  function automatic logic [W-1:0] mag(input logic s, input logic [W-1:0] x);
    return (s && x[W-1]) ? (~x + 1'b1) : x;
  endfunction

  always_comb begin
    sh  = {r_r, q_r[W-1]};
    fit = (sh >= {1'b0, d_r});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      done_r <= 1'b0;
      cnt    <= '0;
    end else begin
      done_r <= 1'b0;
      if (go) begin
        active <= 1'b1;
        cnt    <= '0;
        q_r    <= mag(sgn, a);
        d_r    <= mag(sgn, b);
        r_r    <= '0;
        neg_r  <= sgn & a[W-1];
        neg_q  <= sgn & (a[W-1] ^ b[W-1]);
        dz     <= (b == '0);
      end else if (active) begin
        if (fit) begin
          r_r <= sh[W-1:0] - d_r;
          q_r <= {q_r[W-2:0], 1'b1};
        end else begin
          r_r <= sh[W-1:0];
          q_r <= {q_r[W-2:0], 1'b0};
        end
        cnt <= cnt + 1'b1;
        if (cnt == CW'(W - 1)) begin
          active <= 1'b0;
          done_r <= 1'b1;
        end
      end
    end
  end

  assign done = done_r;
  assign quo  = (neg_q && !dz) ? (~q_r + 1'b1) : q_r;
  assign rem  = neg_r ? (~r_r + 1'b1) : r_r;
endmodule

// File: rtl/hilo_muldiv.sv
module hilo_muldiv
  import hilo_pkg::*;
#(
  parameter int W       = 32,
  parameter int MUL_LAT = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [2:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o,
  output logic         busy
);
  logic           accept, mul_go, div_go, sgn;
  logic           mul_done, div_done;
  logic [2*W-1:0] prod;
  logic [W-1:0]   quo, rem;
  logic [W-1:0]   hi_q, lo_q;
  logic           busy_q;

  assign accept = start & ~busy_q;
  assign mul_go = accept & ((op == OP_MULS) | (op == OP_MULU));
  assign div_go = accept & ((op == OP_DIVS) | (op == OP_DIVU));
  assign sgn    = (op == OP_MULS) | (op == OP_DIVS);

  hilo_mul #(.W(W), .LAT(MUL_LAT)) u_mul (
    .clk(clk), .rst(rst), .go(mul_go), .sgn(sgn),
    .a(opa), .b(opb), .done(mul_done), .prod(prod)
  );

  hilo_div #(.W(W)) u_div (
    .clk(clk), .rst(rst), .go(div_go), .sgn(sgn),
    .a(opa), .b(opb), .done(div_done), .quo(quo), .rem(rem)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q   <= '0;
      lo_q   <= '0;
      busy_q <= 1'b0;
    end else begin
      if (mul_go || div_go) busy_q <= 1'b1;
      if (mul_done) begin
        hi_q   <= prod[2*W-1:W];
        lo_q   <= prod[W-1:0];
        busy_q <= 1'b0;
      end
      if (div_done) begin
        hi_q   <= rem;
        lo_q   <= quo;
        busy_q <= 1'b0;
      end
      if (accept && op == OP_MTHI) hi_q <= opa;
      if (accept && op == OP_MTLO) lo_q <= opa;
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;
  assign busy = busy_q;
endmodule

// File: rtl/hilo_muldiv_chk.sv
module hilo_muldiv_chk
  import hilo_pkg::*;
#(
  parameter int W       = 32,
  parameter int MUL_LAT = 2
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic [2:0]   op,
  input logic [W-1:0] opa,
  input logic [W-1:0] hi,
  input logic [W-1:0] lo,
  input logic         busy
);
  logic [15:0] len, exp_len;
  logic        is_mul, is_div;

  assign is_mul = (op == OP_MULS) || (op == OP_MULU);
  assign is_div = (op == OP_DIVS) || (op == OP_DIVU);

  always_ff @(posedge clk) begin
    if (rst) begin
      len     <= '0;
      exp_len <= '0;
    end else begin
      len <= busy ? len + 16'd1 : 16'd0;
      if (start && !busy && is_mul) exp_len <= 16'(MUL_LAT);
      if (start && !busy && is_div) exp_len <= 16'(W + 1);
    end
  end

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!busy && hi == '0 && lo == '0));

  a_r7_mthi_only: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && op == OP_MTHI) |=> (hi == $past(opa) && $stable(lo) && !busy));

  a_r7_mtlo_only: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && op == OP_MTLO) |=> (lo == $past(opa) && $stable(hi) && !busy));

  a_r8_launch_busy: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && (is_mul || is_div)) |=> busy);

  a_r8_hold_while_busy: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!busy || ($stable(hi) && $stable(lo))));

  a_r8_busy_length: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (len == exp_len));

  a_r10_reserved_noop: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && op[2] && op[1]) |=> ($stable(hi) && $stable(lo) && !busy));
endmodule

bind hilo_muldiv hilo_muldiv_chk #(.W(W), .MUL_LAT(MUL_LAT)) u_chk (
  .clk(clk), .rst(rst), .start(start), .op(op), .opa(opa),
  .hi(hi_o), .lo(lo_o), .busy(busy)
);

// File: tb/hilo_muldiv_tb.sv
module hilo_muldiv_tb;
  localparam int W    = 6;
  localparam int ML   = 2;
  localparam int TCLK = 10;
  localparam int N    = 1 << W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [2:0]   op = '0;
  logic [W-1:0] opa = '0, opb = '0;
  logic [W-1:0] hi_o, lo_o;
  logic         busy;

  int checks = 0;
  int fails  = 0;
  bit hold_bad;

  always #(TCLK/2) clk = ~clk;

  hilo_muldiv #(.W(W), .MUL_LAT(ML)) u_dut (
    .clk(clk), .rst(rst), .start(start), .op(op), .opa(opa), .opb(opb),
    .hi_o(hi_o), .lo_o(lo_o), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int sx(input int v);
    return v[W-1] ? v - N : v;
  endfunction

  function automatic logic [2*W-1:0] model(input int o, input int a, input int b);
    longint p;
    int q, r;
    logic [W-1:0] ones;
    ones = '1;
    case (o)
      0: begin p = longint'(sx(a)) * longint'(sx(b)); return p[2*W-1:0]; end
      1: begin p = longint'(a) * longint'(b); return p[2*W-1:0]; end
      default: begin
        if (b == 0) return {a[W-1:0], ones};
        if (o == 2) begin q = sx(a) / sx(b); r = sx(a) % sx(b); end
        else        begin q = a / b;         r = a % b;         end
        return {r[W-1:0], q[W-1:0]};
      end
    endcase
  endfunction

  task automatic run_op(input logic [2:0] o, input logic [W-1:0] x, input logic [W-1:0] y,
                        output int n);
    logic [W-1:0] h0, l0;
    @(negedge clk);
    start = 1'b1; op = o; opa = x; opb = y;
    h0 = hi_o; l0 = lo_o;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    hold_bad = 1'b0;
    while (busy) begin
      n++;
      if (hi_o !== h0 || lo_o !== l0) hold_bad = 1'b1;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    logic [2*W-1:0] e;
    string tag;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && hi_o == 0 && lo_o == 0, "R1 reset", {hi_o, lo_o, busy}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && hi_o == 0 && lo_o == 0, "R1 after reset", {hi_o, lo_o, busy}, 0);

    // R7: move-to writes only the named register
    run_op(3'd4, 6'h2a, 6'h00, n);
    chk(hi_o == 6'h2a && lo_o == 0 && n == 0, "R7 mthi", {hi_o, lo_o}, {6'h2a, 6'h00});
    run_op(3'd5, 6'h15, 6'h3f, n);
    chk(hi_o == 6'h2a && lo_o == 6'h15 && n == 0, "R7 mtlo", {hi_o, lo_o}, {6'h2a, 6'h15});

    // R10: reserved codes leave HI/LO untouched
    run_op(3'd6, 6'h01, 6'h01, n);
    chk(hi_o == 6'h2a && lo_o == 6'h15 && n == 0, "R10 code6", {hi_o, lo_o}, {6'h2a, 6'h15});
    run_op(3'd7, 6'h3f, 6'h3f, n);
    chk(hi_o == 6'h2a && lo_o == 6'h15 && n == 0, "R10 code7", {hi_o, lo_o}, {6'h2a, 6'h15});

    // R9: move-to strobe arriving one cycle into a divide is dropped
    @(negedge clk);
    start = 1'b1; op = 3'd3; opa = 6'd37; opb = 6'd5;
    @(negedge clk);
    op = 3'd4; opa = 6'h3c;
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    chk(hi_o == 6'd2 && lo_o == 6'd7, "R9 start while busy", {hi_o, lo_o}, {6'd2, 6'd7});
    @(negedge clk);
    chk(hi_o == 6'd2 && lo_o == 6'd7, "R9 no late write", {hi_o, lo_o}, {6'd2, 6'd7});

    // R2 R3 R4 R5 R6 R8: full operand sweep
    for (int o = 0; o < 4; o++) begin
      for (int a = 0; a < N; a++) begin
        for (int b = 0; b < N; b++) begin
          run_op(3'(o), a[W-1:0], b[W-1:0], n);
          e = model(o, a, b);
          if (o >= 2 && b == 0)                       tag = "R6 divide by zero";
          else if (o == 0)                            tag = "R2 signed multiply";
          else if (o == 1)                            tag = "R3 unsigned multiply";
          else if (o == 2)                            tag = "R4 signed divide";
          else                                        tag = "R5 unsigned divide";
          chk({hi_o, lo_o} === e, tag, {hi_o, lo_o}, e);
          chk(n == ((o < 2) ? ML : W + 1), "R8 busy length", n, (o < 2) ? ML : W + 1);
          chk(!hold_bad, "R8 hold while busy", hold_bad, 0);
        end
      end
    end

    // R4: most negative over minus one, explicitly
    run_op(3'd2, 6'h20, 6'h3f, n);
    chk(lo_o == 6'h20 && hi_o == 6'h00, "R4 min div -1", {hi_o, lo_o}, {6'h00, 6'h20});

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule